// File: doc/BRIEF.md
# Inter-Processor Interrupt Flag Bank

A bank of interrupt flags that one processor (the sender) uses to signal another (the receiver). The sender owns two write addresses: one sets flags for every 1 bit written, the other clears them. The receiver owns one write address that acknowledges, and so clears, flags. Both processors can read the flag vector at any time. This lets the sender poll whether a flag has been acknowledged before it raises that flag again.

Each flag drives its own interrupt line towards the receiver. A line is raised only when its flag goes from 0 to 1. When a set and a clear or acknowledge reach the same flag in the same cycle, the set wins. The receiver runs from a clock enable derived from the sender clock, at either full or half rate; a parameter selects the rate. The block makes that strobe itself and presents it on a port.

A pending interrupt is held until the receiver's next enabled cycle, so a half-rate receiver sees each one exactly once. Receiver writes are taken only on enabled cycles. Writes to the flag address itself are discarded on both ports, which keeps read-modify-write races out of the flag state.

Top module: `ipi_flag_bank`

## Requirements
- R1: A sender write to address 1 forces every flag whose data bit is 1 to 1 on the next cycle; flags whose data bit is 0 keep their value.
- R2: A sender write to address 2 forces every flag whose data bit is 1 to 0 on the next cycle, unless R4 applies.
- R3: A receiver write to address 3 on a cycle with `rx_ce_o` high forces every flag whose data bit is 1 to 0 on the next cycle, unless R4 applies.
- R4: When a set reaches a flag in the same cycle as a clear or acknowledge, the flag is 1 on the next cycle.
- R5: An interrupt line rises only in the cycle after its flag goes 0 to 1, and always does so then. Setting a flag that is already 1 gives no new interrupt, whether or not a clear or acknowledge arrives with it. Two sets before an acknowledge give exactly one interrupt.
- R6: A receiver acknowledge on a cycle with `rx_ce_o` low leaves all flags unchanged.
- R7: With `RX_HALF_RATE` = 0, `rx_ce_o` is always 1. With `RX_HALF_RATE` = 1, it is 1 in the first cycle after reset and then alternates every cycle.
- R8: A raised interrupt line stays high up to and including the next cycle with `rx_ce_o` high, then falls unless its flag rises again.
- R9: Writes to address 0 on either port, and receiver writes to addresses 1 and 2, leave the flags unchanged.
- R10: A synchronous active-high `rst` clears all flags and all interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sender clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_en | input | 1 | Sender write strobe |
| tx_addr | input | 2 | Sender address: 0 flags (read-only), 1 set, 2 clear |
| tx_wdata | input | NUM_FLAGS | Sender write data, one bit per flag |
| rx_wr_en | input | 1 | Receiver write strobe, taken only when `rx_ce_o` is high |
| rx_addr | input | 2 | Receiver address: 0 flags (read-only), 3 acknowledge |
| rx_wdata | input | NUM_FLAGS | Receiver write data, one bit per flag |
| flags_o | output | NUM_FLAGS | Flag vector, readable by both sides |
| rx_irq_o | output | NUM_FLAGS | Per-flag interrupt lines to the receiver |
| rx_ce_o | output | 1 | Receiver clock-enable strobe |

## Verification
The bench drives a full-rate and a half-rate instance with the same stimulus. A behavioural model is compared against both on every cycle. Directed phases use the following patterns:
- Separate set, clear and acknowledge writes show that each port acts alone.
- A set and an acknowledge on the same cycle, hitting both a fresh flag and one already at 1, tell the set-wins rule apart from a simple last-writer rule. They also show whether a redundant set can raise a spurious interrupt.
- A double set before the acknowledge, with pulses counted on enabled cycles, separates edge-triggered interrupts from level-triggered ones.
- An acknowledge timed onto an off-strobe cycle separates the two instances.
- A long stretch of random mixed writes covers coincidences that directed cases miss.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] TX_A_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] TX_A_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] TX_A_CLR  = 2'd2;

  localparam logic [ADDR_W-1:0] RX_A_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] RX_A_ACK  = 2'd3;
endpackage

// File: rtl/ipi_rx_strobe.sv
module ipi_rx_strobe #(
  parameter bit HALF_RATE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output logic ce_o
);
  logic ce_q;

  generate
    if (HALF_RATE) begin : g_half
      always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b1;
        else     ce_q <= ~ce_q;
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b1;
        else     ce_q <= 1'b1;
      end
    end
  endgenerate

  assign ce_o = ce_q;
endmodule

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 tx_wr_en,
  input  logic [ADDR_W-1:0]    tx_addr,
  input  logic [NUM_FLAGS-1:0] tx_wdata,
  input  logic                 rx_wr_en,
  input  logic [ADDR_W-1:0]    rx_addr,
  input  logic [NUM_FLAGS-1:0] rx_wdata,
  input  logic                 rx_ce,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o
);
  logic tx_set_hit;
  logic tx_clr_hit;
  logic rx_ack_hit;

  always_comb begin
    tx_set_hit = tx_wr_en && (tx_addr == TX_A_SET);
    tx_clr_hit = tx_wr_en && (tx_addr == TX_A_CLR);
    // receiver side only samples on its own enabled cycles
    rx_ack_hit = rx_wr_en && rx_ce && (rx_addr == RX_A_ACK);
  end

  always_comb begin
    set_o = tx_set_hit ? tx_wdata : '0;
    clr_o = (tx_clr_hit ? tx_wdata : '0) | (rx_ack_hit ? rx_wdata : '0);
  end
endmodule

// File: rtl/ipi_flag_core.sv
module ipi_flag_core #(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] rise_o
);
  logic [NUM_FLAGS-1:0] flag_q;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      // set dominates any clear or acknowledge in the same cycle
      always_ff @(posedge clk) begin
        if (rst)           flag_q[i] <= 1'b0;
        else if (set_i[i]) flag_q[i] <= 1'b1;
        else if (clr_i[i]) flag_q[i] <= 1'b0;
      end
      assign rise_o[i] = set_i[i] & ~flag_q[i];
    end
  endgenerate

  assign flags_o = flag_q;
endmodule

// File: rtl/ipi_irq_hold.sv
module ipi_irq_hold #(
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] rise_i,
  input  logic                 rx_ce,
  output logic [NUM_FLAGS-1:0] irq_o
);
  logic [NUM_FLAGS-1:0] pend_q;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_pend
      // a new rise re-arms; otherwise drop once an enabled cycle has shown it
      always_ff @(posedge clk) begin
        if (rst)            pend_q[i] <= 1'b0;
        else if (rise_i[i]) pend_q[i] <= 1'b1;
        else if (rx_ce)     pend_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign irq_o = pend_q;
endmodule

// File: rtl/ipi_flag_bank.sv
module ipi_flag_bank
  import ipi_pkg::*;
#(
  parameter int NUM_FLAGS    = 32,
  parameter bit RX_HALF_RATE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_wr_en,
  input  logic [1:0]           tx_addr,
  input  logic [NUM_FLAGS-1:0] tx_wdata,
  input  logic                 rx_wr_en,
  input  logic [1:0]           rx_addr,
  input  logic [NUM_FLAGS-1:0] rx_wdata,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] rx_irq_o,
  output logic                 rx_ce_o
);
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic [NUM_FLAGS-1:0] rise_v;
  logic                 ce;

  ipi_rx_strobe #(.HALF_RATE(RX_HALF_RATE)) u_strobe (
    .clk  (clk),
    .rst  (rst),
    .ce_o (ce)
  );

  ipi_wr_decode #(.NUM_FLAGS(NUM_FLAGS)) u_decode (
    .tx_wr_en (tx_wr_en),
    .tx_addr  (tx_addr),
    .tx_wdata (tx_wdata),
    .rx_wr_en (rx_wr_en),
    .rx_addr  (rx_addr),
    .rx_wdata (rx_wdata),
    .rx_ce    (ce),
    .set_o    (set_v),
    .clr_o    (clr_v)
  );

  ipi_flag_core #(.NUM_FLAGS(NUM_FLAGS)) u_core (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flags_o (flags_o),
    .rise_o  (rise_v)
  );

  ipi_irq_hold #(.NUM_FLAGS(NUM_FLAGS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise_v),
    .rx_ce  (ce),
    .irq_o  (rx_irq_o)
  );

  assign rx_ce_o = ce;
endmodule

// File: rtl/ipi_flag_bank_chk.sv
module ipi_flag_bank_chk
  import ipi_pkg::*;
#(
  parameter int NUM_FLAGS    = 32,
  parameter bit RX_HALF_RATE = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tx_wr_en,
  input logic [1:0]           tx_addr,
  input logic [NUM_FLAGS-1:0] tx_wdata,
  input logic                 rx_wr_en,
  input logic [1:0]           rx_addr,
  input logic [NUM_FLAGS-1:0] rx_wdata,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [NUM_FLAGS-1:0] rx_irq_o,
  input logic                 rx_ce_o
);
  logic tx_set, tx_clr, tx_flag, rx_ack, rx_ack_live;
  assign tx_set      = tx_wr_en && (tx_addr == TX_A_SET);
  assign tx_clr      = tx_wr_en && (tx_addr == TX_A_CLR);
  assign tx_flag     = tx_wr_en && (tx_addr == TX_A_FLAG);
  assign rx_ack      = rx_wr_en && (rx_addr == RX_A_ACK);
  assign rx_ack_live = rx_ack && rx_ce_o;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    tx_set |=> ((flags_o & $past(tx_wdata)) == $past(tx_wdata))); // R1
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
    (tx_set && !rx_ack_live) |=> ((flags_o & ~$past(tx_wdata)) == ($past(flags_o) & ~$past(tx_wdata)))); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> ((flags_o & $past(tx_wdata)) == '0)); // R2
  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (rx_ack_live && !tx_set) |=> ((flags_o & $past(rx_wdata)) == '0)); // R3
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
    (tx_set && rx_ack_live) |=> ((flags_o & $past(tx_wdata & rx_wdata)) == $past(tx_wdata & rx_wdata))); // R4
  AST_IRQ_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ((rx_irq_o & ~$past(rx_irq_o) & ~(flags_o & ~$past(flags_o))) == '0)); // R5
  AST_RISE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (((flags_o & ~$past(flags_o)) & ~rx_irq_o) == '0)); // R5
  AST_ACK_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !rx_ce_o && !tx_wr_en) |=> (flags_o == $past(flags_o))); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (!rx_ce_o && (rx_irq_o != '0)) |=> ((rx_irq_o & $past(rx_irq_o)) == $past(rx_irq_o))); // R8
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rx_ce_o && (rx_irq_o != '0)) |=> ((rx_irq_o & $past(rx_irq_o) & ~(flags_o & ~$past(flags_o))) == '0)); // R8
  AST_FLAG_ADDR_INERT: assert property (@(posedge clk) disable iff (rst)
    (tx_flag && !rx_ack_live) |=> (flags_o == $past(flags_o))); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((flags_o == '0) && (rx_irq_o == '0))); // R10

  generate
    if (RX_HALF_RATE) begin : g_half_chk
      AST_STROBE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        rx_ce_o |=> !rx_ce_o); // R7
    end else begin : g_full_chk
      AST_STROBE_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rx_ce_o); // R7
    end
  endgenerate
endmodule

bind ipi_flag_bank ipi_flag_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .RX_HALF_RATE(RX_HALF_RATE)
) u_chk (
  .clk(clk), .rst(rst),
  .tx_wr_en(tx_wr_en), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
  .rx_wr_en(rx_wr_en), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
  .flags_o(flags_o), .rx_irq_o(rx_irq_o), .rx_ce_o(rx_ce_o)
);

// File: tb/ipi_flag_bank_tb.sv
module ipi_flag_bank_tb;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_wr_en = 1'b0;
  logic [1:0] tx_addr = '0;
  logic [N-1:0] tx_wdata = '0;
  logic rx_wr_en = 1'b0;
  logic [1:0] rx_addr = '0;
  logic [N-1:0] rx_wdata = '0;

  logic [N-1:0] f_flags, f_irq, h_flags, h_irq;
  logic f_ce, h_ce;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ipi_flag_bank #(.NUM_FLAGS(N), .RX_HALF_RATE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .tx_wr_en(tx_wr_en), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .rx_wr_en(rx_wr_en), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .flags_o(f_flags), .rx_irq_o(f_irq), .rx_ce_o(f_ce));

  ipi_flag_bank #(.NUM_FLAGS(N), .RX_HALF_RATE(1'b1)) u_dut_half (
    .clk(clk), .rst(rst), .tx_wr_en(tx_wr_en), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .rx_wr_en(rx_wr_en), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .flags_o(h_flags), .rx_irq_o(h_irq), .rx_ce_o(h_ce));

  // behavioural reference: index 0 full rate, index 1 half rate
  logic [N-1:0] m_flag [2];
  logic [N-1:0] m_irq  [2];
  int cyc = 0;
  int cnt_f [N];
  int cnt_h [N];

  function automatic bit model_ce(input int k);
    return (k == 0) ? 1'b1 : ((cyc % 2) == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin m_flag[k] = '0; m_irq[k] = '0; end
      cyc = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit ce;
        ce = model_ce(k);
        for (int b = 0; b < N; b++) begin
          bit s, c;
          s = tx_wr_en && tx_addr == 2'd1 && tx_wdata[b];
          c = (tx_wr_en && tx_addr == 2'd2 && tx_wdata[b]) ||
              (rx_wr_en && rx_addr == 2'd3 && ce && rx_wdata[b]);
          if (s && !m_flag[k][b]) m_irq[k][b] = 1'b1;
          else if (ce)            m_irq[k][b] = 1'b0;
          if (s)      m_flag[k][b] = 1'b1;
          else if (c) m_flag[k][b] = 1'b0;
        end
      end
      cyc++;
    end
  end

  task automatic check_vec(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check_vec("full flags", f_flags, m_flag[0]);
      check_vec("full irq",   f_irq,   m_irq[0]);
      check_vec("half flags", h_flags, m_flag[1]);
      check_vec("half irq",   h_irq,   m_irq[1]);
      check_vec("full strobe R7", {{(N-1){1'b0}}, f_ce}, {{(N-1){1'b0}}, model_ce(0)});
      check_vec("half strobe R7", {{(N-1){1'b0}}, h_ce}, {{(N-1){1'b0}}, model_ce(1)});
      for (int b = 0; b < N; b++) begin
        if (f_irq[b]) cnt_f[b]++;
        if (h_ce && h_irq[b]) cnt_h[b]++;
      end
    end
  end

  task automatic put(input logic tw, input logic [1:0] ta, input logic [N-1:0] td,
                     input logic rw, input logic [1:0] ra, input logic [N-1:0] rd);
    tx_wr_en = tw; tx_addr = ta; tx_wdata = td;
    rx_wr_en = rw; rx_addr = ra; rx_wdata = rd;
  endtask

  task automatic drive(input logic tw, input logic [1:0] ta, input logic [N-1:0] td,
                       input logic rw, input logic [1:0] ra, input logic [N-1:0] rd);
    @(negedge clk); #1;
    put(tw, ta, td, rw, ra, rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
  endtask

  task automatic clear_counts();
    for (int b = 0; b < N; b++) begin cnt_f[b] = 0; cnt_h[b] = 0; end
  endtask

  task automatic check_int(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  initial begin
    clear_counts();
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    // R10: reset state
    @(negedge clk); #2;
    cur_req = "R10";
    check_vec("reset flags", f_flags | h_flags, '0);
    check_vec("reset irq",   f_irq | h_irq,     '0);

    // R7: strobe pattern
    begin
      logic a, b2;
      cur_req = "R7";
      @(negedge clk); #2 a = h_ce;
      @(negedge clk); #2 b2 = h_ce;
      check_int("half strobe toggles", int'(a != b2), 1);
      check_int("full strobe high", int'(f_ce), 1);
    end

    // R1: set
    cur_req = "R1";
    drive(1'b1, 2'd1, 32'h0000_00F1, 1'b0, 2'd0, '0);
    drive(1'b1, 2'd1, 32'h0100_0000, 1'b0, 2'd0, '0);
    idle(3);
    check_vec("flags after sets", f_flags, 32'h0100_00F1);

    // R2: sender clear
    cur_req = "R2";
    drive(1'b1, 2'd2, 32'h0000_0011, 1'b0, 2'd0, '0);
    idle(2);
    check_vec("flags after clear", f_flags, 32'h0100_00E0);

    // R3: acknowledge held two cycles, so both instances take it
    cur_req = "R3";
    drive(1'b0, 2'd0, '0, 1'b1, 2'd3, 32'h0000_0020);
    drive(1'b0, 2'd0, '0, 1'b1, 2'd3, 32'h0000_0020);
    idle(2);
    check_vec("ack full", f_flags, 32'h0100_00C0);
    check_vec("ack half", h_flags, 32'h0100_00C0);

    // R6: acknowledge on an off-strobe cycle of the half-rate instance
    cur_req = "R6";
    drive(1'b1, 2'd1, 32'h0000_0008, 1'b0, 2'd0, '0);
    idle(2);
    @(negedge clk); #1;
    while ((cyc % 2) == 0) begin put(1'b0, 2'd0, '0, 1'b0, 2'd0, '0); @(negedge clk); #1; end
    put(1'b0, 2'd0, '0, 1'b1, 2'd3, 32'h0000_0008);
    idle(1);
    check_int("half ignores off-strobe ack", int'(h_flags[3]), 1);
    check_int("full takes ack", int'(f_flags[3]), 0);

    // R4 and R5: set with coincident acknowledge, fresh and already-set flags
    cur_req = "R4";
    idle(3);
    clear_counts();
    drive(1'b1, 2'd1, 32'h0000_0400, 1'b1, 2'd3, 32'h0000_0400);
    idle(3);
    check_int("fresh flag set wins", int'(f_flags[10] & h_flags[10]), 1);
    cur_req = "R5";
    drive(1'b1, 2'd1, 32'h0000_0400, 1'b1, 2'd3, 32'h0000_0400);
    drive(1'b1, 2'd1, 32'h0000_0400, 1'b1, 2'd3, 32'h0000_0400);
    idle(4);
    check_int("one irq full bit10", cnt_f[10], 1);
    check_int("one irq half bit10", cnt_h[10], 1);

    // R5: double set before acknowledge
    clear_counts();
    drive(1'b1, 2'd1, 32'h0000_0200, 1'b0, 2'd0, '0);
    idle(1);
    drive(1'b1, 2'd1, 32'h0000_0200, 1'b0, 2'd0, '0);
    idle(4);
    check_int("double set full bit9", cnt_f[9], 1);
    check_int("double set half bit9", cnt_h[9], 1);

    // R8: pulse seen on exactly one enabled cycle per rise after ack and re-set
    cur_req = "R8";
    drive(1'b1, 2'd2, 32'h0000_0200, 1'b0, 2'd0, '0);
    drive(1'b1, 2'd1, 32'h0000_0200, 1'b0, 2'd0, '0);
    idle(4);
    check_int("re-set full bit9", cnt_f[9], 2);
    check_int("re-set half bit9", cnt_h[9], 2);

    // R9: writes to flag address and unused receiver addresses
    cur_req = "R9";
    begin
      logic [N-1:0] before_f, before_h;
      @(negedge clk); #2 before_f = f_flags; before_h = h_flags;
      put(1'b1, 2'd0, '1, 1'b1, 2'd0, '1);
      drive(1'b0, 2'd0, '0, 1'b1, 2'd1, '1);
      drive(1'b0, 2'd0, '0, 1'b1, 2'd2, '1);
      drive(1'b1, 2'd3, '1, 1'b0, 2'd0, '0);
      idle(2);
      check_vec("flags untouched full", f_flags, before_f);
      check_vec("flags untouched half", h_flags, before_h);
    end

    // mixed random traffic, model compared every cycle (R1 R2 R3 R4 R5 R6 R8)
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] d1, d2;
      d1 = $urandom() & $urandom();
      d2 = $urandom() & $urandom();
      drive($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), d1,
            $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), d2);
    end
    idle(4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule